// File: doc/BRIEF.md
# SD card SPI initialization sequencer

This block walks a freshly powered SD or MMC card from power-up into the ready state over an SPI link and works out what kind of card it is. It does not frame commands or shift bits itself. It hands a command index and a 32-bit argument to a command framer and waits for the framer's one-byte response. It also asks a byte engine for single 0xFF transfers, which it uses both for the initial clocking and to collect the bytes that trail some responses. It owns the chip-select request and chooses between the slow and the fast SPI clock.

The sequencer branches on the card's answers. Cards that accept the interface-condition query are second-generation SD cards, and their operating-conditions register tells block addressing apart from byte addressing. Cards that reject the query are probed with the SD operating-condition command. A card that accepts the probe is a first-generation SD card. A card that refuses it is treated as MMC and brought up with the MMC operating-condition command. First-generation SD and MMC cards then get a 512-byte block length.

The result is held until the next start pulse. It is either ready with a type code and the fast clock selected, or error with type code 0. An overall timeout, counted in clock cycles, covers every step after the card first reports idle.

Top module: `sdinit_seq`

## Requirements
- R1: After reset, ready, error, spi_fast, card_sel, cmd_start and byte_start are 0 and card_type is 0.
- R2: A start pulse clears ready, error and card_type, selects the slow clock, and issues NDUMMY byte transfers with card_sel low. Only then is the first command issued: index 0 with argument 0. Every command is issued with card_sel high and spi_fast low.
- R3: If the index-0 command returns anything other than 0x01, the sequence ends with error=1 and card_type=0.
- R4: After idle, index 8 is sent with argument 0x000001AA. A 0x01 response is followed by four byte transfers, and the third and fourth received bytes must be 0x01 and 0xAA, otherwise error.
- R5: A second-generation card gets index 55 (arg 0) then index 41 (arg 0x40000000), repeated until index 41 returns 0. A response above 1 to index 55 repeats index 55. Index 58 (arg 0) and four byte transfers follow. Bit 6 of the first received byte gives card_type 4 (block addressed) when set and 3 (byte addressed) when clear. No index 16 is sent.
- R6: If index 8 does not return 0x01, index 55 then index 41 with argument 0 probe the card. A probe response of 0 or 1 gives card_type 2 (SD first generation). The index 55/41 pair is then repeated until index 41 returns 0, followed by index 16 with argument 512.
- R7: A probe response above 1, from either index 55 or index 41, gives card_type 1 (MMC). Index 1 (arg 0) is then repeated until it returns 0, followed by index 16 with argument 512.
- R8: A nonzero response to index 58 or to index 16 ends the sequence with error=1 and card_type=0.
- R9: On success ready=1, error=0 and spi_fast=1. Ready and error are never both 1, and both hold, with card_type, until the next start.
- R10: If the sequence has not finished TIMEOUT_CYCLES cycles after the idle response, it ends with error=1 and card_type=0, even while a response is outstanding.
- R11: A start pulse while a sequence is running has no effect on the request stream or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins initialization |
| cmd_start | output | 1 | One-cycle request to the command framer |
| cmd_index | output | 6 | Command index for the framer |
| cmd_arg | output | 32 | Command argument for the framer |
| cmd_done | input | 1 | Framer reports a response in rx_data |
| byte_start | output | 1 | One-cycle request for a single 0xFF byte transfer |
| byte_done | input | 1 | Byte engine reports a received byte in rx_data |
| rx_data | input | 8 | Response or received byte, valid with a done pulse |
| card_sel | output | 1 | Chip-select request, 1 = card selected |
| spi_fast | output | 1 | 1 = fast SPI clock, 0 = slow clock |
| ready | output | 1 | Initialization succeeded |
| error | output | 1 | Initialization failed |
| card_type | output | 3 | 0 none, 1 MMC, 2 SD first gen, 3 SD second gen byte addressed, 4 SD second gen block addressed |

## Verification
The assertions assume that start is a single-cycle pulse and that the framer and byte engine raise exactly one done pulse for each request, never without an outstanding request. A done pulse that never arrives is allowed, since the timeout must cover it. The bench's card model answers from an ordered scoreboard of expected requests. It replies exactly once per request, a fixed two cycles after seeing it, and deliberately withholds the reply only in the timeout case. Extra start pulses are applied only while a sequence is in flight.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DUMMY, S_GO_IDLE, S_IFCOND, S_R7, S_V2_APP, S_V2_OPCOND,
    S_OCR_CMD, S_OCR, S_PR_APP, S_PR_OPCOND, S_V1_APP, S_V1_OPCOND,
    S_MMC_OPCOND, S_BLKLEN, S_END
  } seq_state_t;

  typedef enum logic [2:0] {
    CARD_NONE      = 3'd0,
    CARD_MMC       = 3'd1,
    CARD_SD1       = 3'd2,
    CARD_SD2_BYTE  = 3'd3,
    CARD_SD2_BLOCK = 3'd4
  } card_kind_t;

  localparam int unsigned TRAIL_BYTES = 4;

  localparam logic [5:0] IDX_GO_IDLE  = 6'd0;
  localparam logic [5:0] IDX_MMC_OP   = 6'd1;
  localparam logic [5:0] IDX_IF_COND  = 6'd8;
  localparam logic [5:0] IDX_BLKLEN   = 6'd16;
  localparam logic [5:0] IDX_SD_OP    = 6'd41;
  localparam logic [5:0] IDX_APP      = 6'd55;
  localparam logic [5:0] IDX_READ_OCR = 6'd58;

  localparam logic [31:0] ARG_IF_COND = 32'h0000_01AA;
  localparam logic [31:0] ARG_HCS     = 32'h4000_0000;

endpackage

// File: rtl/sdinit_cmdmux.sv
module sdinit_cmdmux
  import sdinit_pkg::*;
#(
  parameter int unsigned BLOCK_LEN = 512
) (
  input  seq_state_t  st,
  output logic [5:0]  idx,
  output logic [31:0] arg,
  output logic        is_byte,
  output logic        sel
);
  localparam logic [31:0] ARG_BLKLEN = 32'(BLOCK_LEN);

  always_comb begin
    idx     = IDX_GO_IDLE;
    arg     = '0;
    is_byte = 1'b0;
    sel     = (st != S_DUMMY);
    unique case (st)
      S_DUMMY, S_R7, S_OCR:           is_byte = 1'b1;
      S_IFCOND:                       begin idx = IDX_IF_COND; arg = ARG_IF_COND; end
      S_V2_APP, S_PR_APP, S_V1_APP:   idx = IDX_APP;
      S_V2_OPCOND:                    begin idx = IDX_SD_OP; arg = ARG_HCS; end
      S_PR_OPCOND, S_V1_OPCOND:       idx = IDX_SD_OP;
      S_OCR_CMD:                      idx = IDX_READ_OCR;
      S_MMC_OPCOND:                   idx = IDX_MMC_OP;
      S_BLKLEN:                       begin idx = IDX_BLKLEN; arg = ARG_BLKLEN; end
      default:                        idx = IDX_GO_IDLE;
    endcase
  end
endmodule

// File: rtl/sdinit_capture.sv
module sdinit_capture #(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned W = NBYTES * 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic [7:0]   din,
  output logic [W-1:0] bytes
);
  always_ff @(posedge clk) begin
    if (rst)        bytes <= '0;
    else if (shift) bytes <= {bytes[W-9:0], din};
  end
endmodule

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
  parameter int unsigned LIMIT = 50_000_000,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  output logic expired
);
  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = armed && (cnt == CW'(LIMIT));
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int unsigned NDUMMY         = 10,
  parameter int unsigned TIMEOUT_CYCLES = 50_000_000,
  parameter int unsigned BLOCK_LEN      = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        cmd_start,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  input  logic        cmd_done,
  output logic        byte_start,
  input  logic        byte_done,
  input  logic [7:0]  rx_data,
  output logic        card_sel,
  output logic        spi_fast,
  output logic        ready,
  output logic        error,
  output logic [2:0]  card_type
);
  localparam int unsigned CAPW = TRAIL_BYTES * 8;
  localparam int unsigned BCW  = $clog2((NDUMMY > TRAIL_BYTES ? NDUMMY : TRAIL_BYTES) + 1);

  seq_state_t st, nxt_st;
  card_kind_t kind, nxt_kind;
  logic           waiting;
  logic [BCW-1:0] bcnt;

  logic [5:0]  mux_idx;
  logic [31:0] mux_arg;
  logic        mux_byte, mux_sel;
  logic        running, accept, done;
  logic        fin_ok, fin_bad, tmr_arm, tmr_expired, bcnt_inc, bcnt_clr;
  logic [CAPW-1:0] cap, full;

  assign running = (st != S_IDLE) && (st != S_END);
  assign accept  = start && !running;
  assign done    = running && waiting && (mux_byte ? byte_done : cmd_done);

  sdinit_cmdmux #(.BLOCK_LEN(BLOCK_LEN)) u_mux (
    .st(st), .idx(mux_idx), .arg(mux_arg), .is_byte(mux_byte), .sel(mux_sel)
  );

  sdinit_capture #(.NBYTES(TRAIL_BYTES)) u_cap (
    .clk(clk), .rst(rst), .shift(done && mux_byte), .din(rx_data), .bytes(cap)
  );

  sdinit_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .clr(accept), .arm(tmr_arm), .expired(tmr_expired)
  );

  // trailing bytes including the one arriving now; first byte at the top
  assign full = {cap[CAPW-9:0], rx_data};

  always_comb begin
    nxt_st   = st;
    nxt_kind = kind;
    fin_ok   = 1'b0;
    fin_bad  = 1'b0;
    tmr_arm  = 1'b0;
    bcnt_inc = 1'b0;
    bcnt_clr = 1'b0;
    if (running && tmr_expired) begin
      fin_bad = 1'b1;
    end else if (done) begin
      unique case (st)
        S_DUMMY:
          if (bcnt == BCW'(NDUMMY - 1)) begin nxt_st = S_GO_IDLE; bcnt_clr = 1'b1; end
          else bcnt_inc = 1'b1;
        S_GO_IDLE:
          if (rx_data == 8'h01) begin nxt_st = S_IFCOND; tmr_arm = 1'b1; end
          else fin_bad = 1'b1;
        S_IFCOND:
          nxt_st = (rx_data == 8'h01) ? S_R7 : S_PR_APP;
        S_R7:
          if (bcnt == BCW'(TRAIL_BYTES - 1)) begin
            bcnt_clr = 1'b1;
            if (full[15:8] == 8'h01 && full[7:0] == 8'hAA) nxt_st = S_V2_APP;
            else fin_bad = 1'b1;
          end else bcnt_inc = 1'b1;
        S_V2_APP:
          if (rx_data <= 8'h01) nxt_st = S_V2_OPCOND;
        S_V2_OPCOND:
          nxt_st = (rx_data == 8'h00) ? S_OCR_CMD : S_V2_APP;
        S_OCR_CMD:
          if (rx_data == 8'h00) nxt_st = S_OCR;
          else fin_bad = 1'b1;
        S_OCR:
          if (bcnt == BCW'(TRAIL_BYTES - 1)) begin
            bcnt_clr = 1'b1;
            nxt_kind = full[CAPW-2] ? CARD_SD2_BLOCK : CARD_SD2_BYTE;
            fin_ok   = 1'b1;
          end else bcnt_inc = 1'b1;
        S_PR_APP:
          if (rx_data > 8'h01) begin nxt_kind = CARD_MMC; nxt_st = S_MMC_OPCOND; end
          else nxt_st = S_PR_OPCOND;
        S_PR_OPCOND:
          if (rx_data <= 8'h01) begin nxt_kind = CARD_SD1; nxt_st = S_V1_APP; end
          else begin nxt_kind = CARD_MMC; nxt_st = S_MMC_OPCOND; end
        S_V1_APP:
          if (rx_data <= 8'h01) nxt_st = S_V1_OPCOND;
        S_V1_OPCOND:
          nxt_st = (rx_data == 8'h00) ? S_BLKLEN : S_V1_APP;
        S_MMC_OPCOND:
          if (rx_data == 8'h00) nxt_st = S_BLKLEN;
        S_BLKLEN:
          if (rx_data == 8'h00) fin_ok = 1'b1;
          else fin_bad = 1'b1;
        default: nxt_st = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind       <= CARD_NONE;
      waiting    <= 1'b0;
      bcnt       <= '0;
      cmd_start  <= 1'b0;
      byte_start <= 1'b0;
      cmd_index  <= '0;
      cmd_arg    <= '0;
      card_sel   <= 1'b0;
      spi_fast   <= 1'b0;
      ready      <= 1'b0;
      error      <= 1'b0;
      card_type  <= CARD_NONE;
    end else begin
      cmd_start  <= 1'b0;
      byte_start <= 1'b0;
      if (accept) begin
        st        <= S_DUMMY;
        kind      <= CARD_NONE;
        waiting   <= 1'b0;
        bcnt      <= '0;
        card_sel  <= 1'b0;
        spi_fast  <= 1'b0;
        ready     <= 1'b0;
        error     <= 1'b0;
        card_type <= CARD_NONE;
      end else if (fin_bad) begin
        st        <= S_END;
        waiting   <= 1'b0;
        bcnt      <= '0;
        card_sel  <= 1'b0;
        spi_fast  <= 1'b0;
        ready     <= 1'b0;
        error     <= 1'b1;
        card_type <= CARD_NONE;
      end else if (fin_ok) begin
        st        <= S_END;
        kind      <= nxt_kind;
        waiting   <= 1'b0;
        bcnt      <= '0;
        card_sel  <= 1'b0;
        spi_fast  <= 1'b1;
        ready     <= 1'b1;
        error     <= 1'b0;
        card_type <= nxt_kind;
      end else if (running) begin
        st   <= nxt_st;
        kind <= nxt_kind;
        if (bcnt_clr)      bcnt <= '0;
        else if (bcnt_inc) bcnt <= bcnt + 1'b1;
        if (done) begin
          waiting <= 1'b0;
        end else if (!waiting) begin
          waiting   <= 1'b1;
          card_sel  <= mux_sel;
          cmd_index <= mux_idx;
          cmd_arg   <= mux_arg;
          if (mux_byte) byte_start <= 1'b1;
          else          cmd_start  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       cmd_start,
  input logic       byte_start,
  input logic       card_sel,
  input logic       spi_fast,
  input logic       ready,
  input logic       error,
  input logic [2:0] card_type
);
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(ready && error));

  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready);

  assert_error_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  assert_ready_fast_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> (spi_fast && card_type != 3'd0));

  assert_error_type_R10: assert property (@(posedge clk) disable iff (rst)
    error |-> (card_type == 3'd0 && !spi_fast));

  assert_cmd_selected_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (card_sel && !spi_fast));

  assert_single_req_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_start && byte_start));

  assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

  assert_byte_slow_R2: assert property (@(posedge clk) disable iff (rst)
    byte_start |-> !spi_fast);
endmodule

bind sdinit_seq sdinit_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .cmd_start(cmd_start),
  .byte_start(byte_start), .card_sel(card_sel), .spi_fast(spi_fast),
  .ready(ready), .error(error), .card_type(card_type)
);

// File: tb/sdinit_seq_test.sv
`timescale 1ns/1ps
module sdinit_seq_test;
  localparam int unsigned NDUMMY  = 10;
  localparam int unsigned TIMEOUT = 600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cmd_start, byte_start, card_sel, spi_fast, ready, error;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        cmd_done = 1'b0, byte_done = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [2:0]  card_type;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdinit_seq #(.NDUMMY(NDUMMY), .TIMEOUT_CYCLES(TIMEOUT), .BLOCK_LEN(512)) uut (
    .clk(clk), .rst(rst), .start(start), .cmd_start(cmd_start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
    .byte_start(byte_start), .byte_done(byte_done), .rx_data(rx_data),
    .card_sel(card_sel), .spi_fast(spi_fast), .ready(ready), .error(error),
    .card_type(card_type)
  );

  typedef struct {
    bit          is_byte;
    bit          sel;
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [7:0]  resp;
    bit          noreply;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pcmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] resp, input string tag);
    item_t it;
    it.is_byte = 1'b0; it.sel = 1'b1; it.idx = idx; it.arg = arg;
    it.resp = resp; it.noreply = 1'b0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic phang(input logic [5:0] idx, input logic [31:0] arg, input string tag);
    item_t it;
    it.is_byte = 1'b0; it.sel = 1'b1; it.idx = idx; it.arg = arg;
    it.resp = 8'hFF; it.noreply = 1'b1; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pbyte(input bit sel, input logic [7:0] data, input string tag);
    item_t it;
    it.is_byte = 1'b1; it.sel = sel; it.idx = '0; it.arg = '0;
    it.resp = data; it.noreply = 1'b0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pdummy_idle();
    for (int i = 0; i < NDUMMY; i++) pbyte(1'b0, 8'hFF, "R2");
    pcmd(6'd0, 32'h0, 8'h01, "R2");
  endtask

  task automatic pr7(input logic [7:0] b2, input logic [7:0] b3);
    pcmd(6'd8, 32'h1AA, 8'h01, "R4");
    pbyte(1'b1, 8'h00, "R4");
    pbyte(1'b1, 8'h00, "R4");
    pbyte(1'b1, b2, "R4");
    pbyte(1'b1, b3, "R4");
  endtask

  // monitor / card model: pops expected requests and answers them
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_start || byte_start) begin
        if (sb.size() == 0) begin
          chk("R2", "unexpected request", 64'(cmd_index), 64'hFFFF);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(it.tag, "request kind", 64'(byte_start), 64'(it.is_byte));
          if (it.is_byte) begin
            chk(it.tag, "card_sel on byte", 64'(card_sel), 64'(it.sel));
          end else begin
            chk(it.tag, "cmd index", 64'(cmd_index), 64'(it.idx));
            chk(it.tag, "cmd arg", 64'(cmd_arg), 64'(it.arg));
          end
          if (!it.noreply) begin
            repeat (2) @(negedge clk);
            rx_data = it.resp;
            if (it.is_byte) byte_done = 1'b1;
            else            cmd_done  = 1'b1;
            @(negedge clk);
            cmd_done  = 1'b0;
            byte_done = 1'b0;
          end
        end
      end
    end
  end

  task automatic run(input string tag, input logic [2:0] exp_type, input bit exp_ok,
                     input bit restart_mid, output int cycles);
    logic [2:0] t0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "ready/error cleared on start", {ready, error, card_type}, 5'b0);
    chk("R2", "slow clock after start", 64'(spi_fast), 64'h0);
    cycles = 0;
    while (!(ready || error) && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      start = (restart_mid && (cycles == 20 || cycles == 80));
    end
    start = 1'b0;
    chk(tag, "ready", 64'(ready), 64'(exp_ok));
    chk(tag, "error", 64'(error), 64'(!exp_ok));
    chk(tag, "card_type", 64'(card_type), 64'(exp_type));
    chk(tag, "spi_fast", 64'(spi_fast), 64'(exp_ok));
    chk(tag, "scoreboard drained", 64'(sb.size()), 64'h0);
    t0 = card_type;
    repeat (20) @(negedge clk);
    chk("R9", "result held", {ready, error, card_type}, {exp_ok, !exp_ok, t0});
  endtask

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs",
        {ready, error, spi_fast, card_sel, cmd_start, byte_start, card_type}, 9'b0);

    // R5: second-generation, block addressed (OCR byte0 = 0xC0, bit 6 set)
    pdummy_idle(); pr7(8'h01, 8'hAA);
    pcmd(6'd55, 32'h0, 8'h01, "R5"); pcmd(6'd41, 32'h4000_0000, 8'h01, "R5");
    pcmd(6'd55, 32'h0, 8'h05, "R5");
    pcmd(6'd55, 32'h0, 8'h01, "R5"); pcmd(6'd41, 32'h4000_0000, 8'h00, "R5");
    pcmd(6'd58, 32'h0, 8'h00, "R5");
    pbyte(1'b1, 8'hC0, "R5"); pbyte(1'b1, 8'hFF, "R5");
    pbyte(1'b1, 8'h80, "R5"); pbyte(1'b1, 8'h00, "R5");
    run("R5", 3'd4, 1'b1, 1'b0, cyc);

    // R5: second-generation, byte addressed (OCR byte0 = 0x80)
    pdummy_idle(); pr7(8'h01, 8'hAA);
    pcmd(6'd55, 32'h0, 8'h01, "R5"); pcmd(6'd41, 32'h4000_0000, 8'h00, "R5");
    pcmd(6'd58, 32'h0, 8'h00, "R5");
    pbyte(1'b1, 8'h80, "R5"); pbyte(1'b1, 8'hFF, "R5");
    pbyte(1'b1, 8'h80, "R5"); pbyte(1'b1, 8'h00, "R5");
    run("R5", 3'd3, 1'b1, 1'b0, cyc);

    // R6 + R11: first-generation SD, extra start pulses mid-sequence
    pdummy_idle();
    pcmd(6'd8, 32'h1AA, 8'h05, "R6");
    pcmd(6'd55, 32'h0, 8'h01, "R6"); pcmd(6'd41, 32'h0, 8'h01, "R6");
    pcmd(6'd55, 32'h0, 8'h01, "R6"); pcmd(6'd41, 32'h0, 8'h01, "R6");
    pcmd(6'd55, 32'h0, 8'h01, "R6"); pcmd(6'd41, 32'h0, 8'h00, "R6");
    pcmd(6'd16, 32'd512, 8'h00, "R6");
    run("R11", 3'd2, 1'b1, 1'b1, cyc);

    // R7: MMC via probe index 41 returning 0x05
    pdummy_idle();
    pcmd(6'd8, 32'h1AA, 8'h05, "R7");
    pcmd(6'd55, 32'h0, 8'h01, "R7"); pcmd(6'd41, 32'h0, 8'h05, "R7");
    pcmd(6'd1, 32'h0, 8'h01, "R7"); pcmd(6'd1, 32'h0, 8'h00, "R7");
    pcmd(6'd16, 32'd512, 8'h00, "R7");
    run("R7", 3'd1, 1'b1, 1'b0, cyc);

    // R7: MMC via index 55 rejected
    pdummy_idle();
    pcmd(6'd8, 32'h1AA, 8'hFF, "R7");
    pcmd(6'd55, 32'h0, 8'h05, "R7");
    pcmd(6'd1, 32'h0, 8'h00, "R7");
    pcmd(6'd16, 32'd512, 8'h00, "R7");
    run("R7", 3'd1, 1'b1, 1'b0, cyc);

    // R3: idle command rejected
    for (int i = 0; i < NDUMMY; i++) pbyte(1'b0, 8'hFF, "R2");
    pcmd(6'd0, 32'h0, 8'hFF, "R3");
    run("R3", 3'd0, 1'b0, 1'b0, cyc);

    // R4: trailing bytes mismatch
    pdummy_idle(); pr7(8'h01, 8'hAB);
    run("R4", 3'd0, 1'b0, 1'b0, cyc);

    // R8: block length rejected
    pdummy_idle();
    pcmd(6'd8, 32'h1AA, 8'h05, "R8");
    pcmd(6'd55, 32'h0, 8'h01, "R8"); pcmd(6'd41, 32'h0, 8'h00, "R8");
    pcmd(6'd55, 32'h0, 8'h01, "R8"); pcmd(6'd41, 32'h0, 8'h00, "R8");
    pcmd(6'd16, 32'd512, 8'h04, "R8");
    run("R8", 3'd0, 1'b0, 1'b0, cyc);

    // R8: OCR read rejected
    pdummy_idle(); pr7(8'h01, 8'hAA);
    pcmd(6'd55, 32'h0, 8'h01, "R8"); pcmd(6'd41, 32'h4000_0000, 8'h00, "R8");
    pcmd(6'd58, 32'h0, 8'h05, "R8");
    run("R8", 3'd0, 1'b0, 1'b0, cyc);

    // R10: card never answers the operating-condition command
    pdummy_idle(); pr7(8'h01, 8'hAA);
    pcmd(6'd55, 32'h0, 8'h01, "R10");
    phang(6'd41, 32'h4000_0000, "R10");
    run("R10", 3'd0, 1'b0, 1'b0, cyc);
    chk("R10", "timeout not early", 64'(cyc >= int'(TIMEOUT)), 64'h1);
    chk("R10", "timeout not late", 64'(cyc < int'(TIMEOUT) + 200), 64'h1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule